// File: doc/BRIEF.md
# Burst-Borrow Sample Corrector

This block sits on the output stream of a pipelined 16-tap FIR filter. Each sample from the filter comes with a flag that says whether the stage producing it had to borrow time from the next clock cycle. A single borrow is harmless, because the late data is already captured correctly. A burst is different. When a sample's flag is set and the previous sample's flag was also set, the computed value can no longer be trusted. The block then discards it and emits an estimate in its place.

The estimate is a spline-style interpolation over four trusted neighbours: the two most recent trusted samples before the bad one, and the two samples that follow it. To have the later samples in hand, the block delays the stream by two samples. Each sample is emitted in the cycle after the input that carries the sample two positions later in the stream. When too few trusted neighbours exist, the block repeats its last output value.

Top module: `aec_corrector`

## Requirements
- R1: While reset is held, and after it is released, `out_valid` is 0 and `out_data` is 0 until the first sample is emitted.
- R2: Sample k of the input stream (k counted from 0 after reset) is emitted in the cycle after the input cycle that accepts sample k+2. The first two samples after reset produce no output.
- R3: A sample whose flag is clear is emitted unchanged. So is a sample whose flag is set while the previous sample's flag was clear.
- R4: A sample is marked bad when its flag is set and the flag of the previous accepted sample was also set. Only cycles with `in_valid` high count as samples, so idle cycles between samples neither extend nor break a run. A sample with a clear flag ends the run.
- R5: A bad sample is replaced by (-A2 + 4*A1 + 4*B1 - B2) / 6. The division truncates toward zero, and the result saturates to the signed range of `out_data`.
- R6: A1 and A2 are the most recent and the second most recent unmarked samples emitted before the bad one.
- R7: B1 and B2 are the first and second samples after the bad one. If exactly one of them is marked bad, the other one supplies both B1 and B2.
- R8: If both following samples are marked bad, or fewer than two unmarked samples have been emitted since reset, the bad sample is emitted as a copy of the previous `out_data` value.
- R9: `out_valid` is high for exactly one cycle per emitted sample, and only in a cycle after an input cycle with `in_valid` high. `out_data` does not change while `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | DATA_W | Signed sample from the filter |
| in_borrow | input | 1 | Time-borrow flag for this sample |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | DATA_W | Signed corrected sample |

## Verification
The bench builds the block with DATA_W = 8 and TRIG_RUN = 2. The narrow width means random data together with forced extreme values drives the interpolator into both saturation limits regularly. The flag stream steps through all 256 patterns of eight consecutive flags. This covers every arrangement of isolated borrows, bursts, bad forward neighbours and starved backward history. Random idle gaps are placed between samples to show that a run is counted per sample and not per cycle.

// File: rtl/aec_pkg.sv
package aec_pkg;
  // how the output register is loaded for the sample at the window centre
  typedef enum logic [1:0] {
    SEL_PASS = 2'd0,
    SEL_EST  = 2'd1,
    SEL_HOLD = 2'd2
  } aec_sel_e;

  // number of forward neighbours held back before a decision
  localparam int unsigned AEC_FWD = 2;
endpackage

// File: rtl/aec_run_tracker.sv
module aec_run_tracker #(
  parameter int unsigned TRIG_RUN = 2,
  localparam int unsigned RUN_W = $clog2(TRIG_RUN + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic smp_valid,
  input  logic smp_borrow,
  output logic smp_mark
);
  logic [RUN_W-1:0] run_q;

  // current sample completes a run of TRIG_RUN flagged samples
  always_comb smp_mark = smp_borrow && (run_q >= RUN_W'(TRIG_RUN - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '0;
    end else if (smp_valid) begin
      if (!smp_borrow)
        run_q <= '0;
      else if (run_q != RUN_W'(TRIG_RUN))
        run_q <= run_q + 1'b1;
    end
  end
endmodule

// File: rtl/aec_delay_line.sv
module aec_delay_line #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 2,
  localparam int unsigned FILL_W = $clog2(DEPTH + 1)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          push,
  input  logic [DATA_W-1:0]             push_data,
  input  logic                          push_mark,
  output logic [DEPTH-1:0][DATA_W-1:0]  tap_data,
  output logic [DEPTH-1:0]              tap_mark,
  output logic                          full
);
  logic [FILL_W-1:0] fill_q;

  // stage 0 is the newest entry, stage DEPTH-1 the oldest
  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (push) tap_data[g] <= push_data;
        if (rst)       tap_mark[g] <= 1'b0;
        else if (push) tap_mark[g] <= push_mark;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (push) tap_data[g] <= tap_data[g-1];
        if (rst)       tap_mark[g] <= 1'b0;
        else if (push) tap_mark[g] <= tap_mark[g-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      fill_q <= '0;
    else if (push && fill_q != FILL_W'(DEPTH))
      fill_q <= fill_q + 1'b1;
  end

  always_comb full = (fill_q == FILL_W'(DEPTH));
endmodule

// File: rtl/aec_interp.sv
module aec_interp #(
  parameter int unsigned DATA_W = 16,
  localparam int unsigned SW = DATA_W + 4
) (
  input  logic signed [DATA_W-1:0] a2,
  input  logic signed [DATA_W-1:0] a1,
  input  logic signed [DATA_W-1:0] b1,
  input  logic signed [DATA_W-1:0] b2,
  output logic signed [DATA_W-1:0] est
);
  localparam logic signed [SW-1:0] MAXV = SW'((64'sd1 <<< (DATA_W - 1)) - 64'sd1);
  localparam logic signed [SW-1:0] MINV = -MAXV - SW'(1);
  localparam logic signed [SW-1:0] SIX  = SW'(6);

  logic signed [SW-1:0] xa2, xa1, xb1, xb2, sum, quot;

  always_comb begin
    xa2  = {{4{a2[DATA_W-1]}}, a2};
    xa1  = {{4{a1[DATA_W-1]}}, a1};
    xb1  = {{4{b1[DATA_W-1]}}, b1};
    xb2  = {{4{b2[DATA_W-1]}}, b2};
    sum  = (xa1 <<< 2) + (xb1 <<< 2) - xa2 - xb2;
    quot = sum / SIX;
    if (quot > MAXV)      est = MAXV[DATA_W-1:0];
    else if (quot < MINV) est = MINV[DATA_W-1:0];
    else                  est = quot[DATA_W-1:0];
  end
endmodule

// File: rtl/aec_corrector.sv
module aec_corrector #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned TRIG_RUN = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_data,
  input  logic                     in_borrow,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_data
);
  import aec_pkg::*;
  localparam int unsigned FWD = AEC_FWD;

  logic                          in_mark;
  logic [FWD-1:0][DATA_W-1:0]    tap_data;
  logic [FWD-1:0]                tap_mark;
  logic                          win_full;

  aec_run_tracker #(.TRIG_RUN(TRIG_RUN)) u_run (
    .clk(clk), .rst(rst), .smp_valid(in_valid),
    .smp_borrow(in_borrow), .smp_mark(in_mark)
  );

  aec_delay_line #(.DATA_W(DATA_W), .DEPTH(FWD)) u_dly (
    .clk(clk), .rst(rst), .push(in_valid), .push_data(in_data),
    .push_mark(in_mark), .tap_data(tap_data), .tap_mark(tap_mark),
    .full(win_full)
  );

  // window: centre = oldest tap, first forward = newest tap, second forward = incoming
  logic signed [DATA_W-1:0] ctr_d, fw1_d, fw2_d;
  logic                     ctr_m, fw1_m, fw2_m;
  logic                     fire;

  always_comb begin
    ctr_d = tap_data[FWD-1];
    ctr_m = tap_mark[FWD-1];
    fw1_d = tap_data[0];
    fw1_m = tap_mark[0];
    fw2_d = in_data;
    fw2_m = in_mark;
    fire  = in_valid && win_full;
  end

  // last two unmarked samples that left the centre
  logic signed [DATA_W-1:0] bk1_q, bk2_q;
  logic [1:0]               bk_cnt_q;

  logic signed [DATA_W-1:0] use_b1, use_b2, est;
  aec_sel_e                 sel;

  always_comb begin
    use_b1 = fw1_d;
    use_b2 = fw2_d;
    if (fw1_m) use_b1 = fw2_d;
    if (fw2_m) use_b2 = fw1_d;
    if (!ctr_m)
      sel = SEL_PASS;
    else if ((bk_cnt_q < 2'd2) || (fw1_m && fw2_m))
      sel = SEL_HOLD;
    else
      sel = SEL_EST;
  end

  aec_interp #(.DATA_W(DATA_W)) u_interp (
    .a2(bk2_q), .a1(bk1_q), .b1(use_b1), .b2(use_b2), .est(est)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bk_cnt_q <= '0;
    end else if (fire && !ctr_m) begin
      bk1_q <= ctr_d;
      bk2_q <= bk1_q;
      if (bk_cnt_q != 2'd2) bk_cnt_q <= bk_cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= fire;
      if (fire) begin
        unique case (sel)
          SEL_PASS: out_data <= ctr_d;
          SEL_EST:  out_data <= est;
          default:  out_data <= out_data;
        endcase
      end
    end
  end
endmodule

// File: rtl/aec_corrector_chk.sv
module aec_corrector_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     in_valid,
  input logic signed [DATA_W-1:0] in_data,
  input logic                     in_borrow,
  input logic                     out_valid,
  input logic signed [DATA_W-1:0] out_data
);
  logic signed [DATA_W-1:0] h0, h1, h2;
  logic                     f0, f1, f2, f3;
  logic [1:0]               seen;

  always_ff @(posedge clk) begin
    if (in_valid) begin
      h0 <= in_data; h1 <= h0; h2 <= h1;
    end
    if (rst) begin
      {f0, f1, f2, f3} <= '0;
      seen <= '0;
    end else if (in_valid) begin
      f0 <= in_borrow; f1 <= f0; f2 <= f1; f3 <= f2;
      if (seen != 2'd3) seen <= seen + 1'b1;
    end
  end

  // R2
  first_out_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (seen == 2'd3));

  // R9
  out_after_in_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));

  // R9
  out_steady_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (out_data == $past(out_data)));

  // R3
  pass_through_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !(f2 && f3)) |-> (out_data == h2));
endmodule

bind aec_corrector aec_corrector_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
  .in_borrow(in_borrow), .out_valid(out_valid), .out_data(out_data)
);

// File: tb/test_aec_corrector.sv
module test_aec_corrector;
  localparam int W = 8;
  localparam int NMAX = 4096;
  localparam int MAXV = (1 << (W - 1)) - 1;
  localparam int MINV = -(1 << (W - 1));

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [W-1:0] in_data = '0;
  logic in_borrow = 1'b0;
  logic out_valid;
  logic signed [W-1:0] out_data;

  always #2.5 clk = ~clk;

  aec_corrector #(.DATA_W(W), .TRIG_RUN(2)) i_aec_corrector (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_borrow(in_borrow), .out_valid(out_valid), .out_data(out_data)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;

  int dq [0:NMAX-1];
  bit mq [0:NMAX-1];
  int nin = 0;
  int oj = 0;
  int brun = 0;
  int gb1 = 0, gb2 = 0, gbn = 0;
  int last_out = 0;
  int nsat = 0;
  bit prev_v = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // model of the requirements, evaluated when an output is seen
  task automatic check_out();
    int e, b1, b2, s;
    string tag;
    if (out_valid) begin
      chk(prev_v, "R9 output without input", 0, 1);
      if (oj + 2 >= nin) begin
        chk(0, "R2 early output", oj, nin - 3);
      end else begin
        if (!mq[oj]) begin
          e = dq[oj]; tag = "R3 pass";
          gb2 = gb1; gb1 = dq[oj];
          if (gbn < 2) gbn++;
        end else if (gbn < 2 || (mq[oj+1] && mq[oj+2])) begin
          e = last_out; tag = "R4 R8 hold";
        end else begin
          b1 = mq[oj+1] ? dq[oj+2] : dq[oj+1];
          b2 = mq[oj+2] ? dq[oj+1] : dq[oj+2];
          s = (4 * gb1 + 4 * b1 - gb2 - b2) / 6;
          if (s > MAXV) begin s = MAXV; nsat++; end
          if (s < MINV) begin s = MINV; nsat++; end
          e = s;
          tag = (mq[oj+1] || mq[oj+2]) ? "R4 R6 R7 estimate" : "R4 R5 R6 estimate";
        end
        chk(int'(out_data) == e, tag, int'(out_data), e);
        last_out = e;
      end
      oj++;
    end
  endtask

  task automatic step(input bit v, input int d, input bit f);
    @(negedge clk);
    check_out();
    in_valid  = v;
    in_data   = W'(d);
    in_borrow = f;
    prev_v    = v;
    if (v) begin
      if (f) begin
        mq[nin] = (brun >= 1);
        brun++;
      end else begin
        mq[nin] = 0;
        brun = 0;
      end
      dq[nin] = int'($signed(W'(d)));
      nin++;
    end
  endtask

  function automatic logic [15:0] adv(input logic [15:0] x);
    return {x[14:0], x[15] ^ x[13] ^ x[12] ^ x[10]};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(out_valid == 0 && out_data == 0, "R1 in reset", int'(out_valid), 0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 0 && out_data == 0, "R1 after reset", int'(out_data), 0);
    for (int pat = 0; pat < 256; pat++) begin
      for (int k = 0; k < 8; k++) begin
        int d;
        lfsr = adv(lfsr);
        case (lfsr[10:9])
          2'd0: d = MAXV;
          2'd1: d = MINV;
          default: d = int'($signed(lfsr[W-1:0]));
        endcase
        if (lfsr[12:11] == 2'd0) step(0, 0, 0);   // idle gap, R4 per-sample run
        step(1, d, pat[k]);
      end
    end
    repeat (4) step(0, 0, 0);
    chk(oj == nin - 2, "R2 output count", oj, nin - 2);
    chk(nsat > 0, "R5 saturation reached", nsat, 1);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", oj, nin - 2);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule